// File: doc/BRIEF.md
# Interval Timer Host Register Interface

This block is the byte-wide host side of a three-channel interval timer. A host reaches it through a 2-bit address with separate read and write strobes. Addresses 0, 1 and 2 are the data ports of channels 0, 1 and 2. Address 3 accepts control words. The block decodes those control words and keeps each channel's access mode, counting mode and decimal flag. It steps through the low and high bytes of 16-bit values on both writes and reads. It also holds a one-shot count snapshot and a one-shot status byte for each channel.

The counting logic sits outside this block. Each channel receives a 16-bit load value with a one-cycle load pulse, together with its mode and decimal flag. In return the block takes each channel's live 16-bit count and its output level. A control word with a zero access field freezes one channel's count. A control word with channel field 3 is a read-back command, and it can freeze the count, the status or both for any set of channels in a single write.

Top module: `timer_bus_regif`

## Requirements
- R1: A write to address 3 with bits 7:6 equal to a channel number (0 to 2) and bits 5:4 non-zero sets that channel's access mode to bits 5:4, its mode to bits 3:1 and its decimal flag to bit 0. The new mode and flag appear on the channel outputs in the cycle after the write.
- R2: A write to address 3 with bits 5:4 equal to 0 freezes the selected channel's live count into its count snapshot. It does not change the mode, the decimal flag or the access mode.
- R3: A write to address 3 with bits 7:6 equal to 3 is a read-back. Bit 1 selects channel 0, bit 2 selects channel 1 and bit 3 selects channel 2. For each selected channel, a 0 in bit 5 freezes the count and a 0 in bit 4 freezes the status byte. Channels that are not selected are unaffected.
- R4: The status byte is {output level, 0, access mode[1:0], mode[2:0], decimal flag}, with the output level in bit 7.
- R5: While a count snapshot or a status byte is held and not yet fully read, further freeze requests of the same kind for that channel are ignored.
- R6: A data-port read returns a held status byte first, then a held count snapshot, and only then the live count. Reading the status byte releases only the status byte.
- R7: In low-then-high access (code 3), the first data write is kept and the second write loads {second, first}. The load pulse lasts one cycle and comes in the cycle after the second write.
- R8: In low-only access (code 1), a data write loads {8'h00, byte}. In high-only access (code 2), it loads {byte, 8'h00}.
- R9: Live reads return the low byte in low-only access and the high byte in high-only access. In low-then-high access they alternate, starting with the low byte.
- R10: A count snapshot taken in low-then-high access is read as the low byte and then the high byte, and is released after the high byte. One taken in low-only or high-only access is released after a single read.
- R11: A control word that sets a channel's access mode resets both of that channel's byte pointers to the low byte.
- R12: A write to address 3 never produces a load pulse, and a read from address 3 returns 8'h00.
- R13: After reset every channel is in low-then-high access with mode 3 and decimal flag 0, with nothing held, no load pulse and read data 8'h00.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 2 | Register select: 0 to 2 channel data ports, 3 control word |
| bus_wr | input | 1 | Write strobe, one byte per cycle |
| bus_rd | input | 1 | Read strobe, one byte per cycle |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Registered read data, valid the cycle after the read strobe |
| ch_load_val | output | 48 | Per-channel 16-bit load value, channel n in bits 16n+15:16n |
| ch_load_stb | output | 3 | Per-channel one-cycle load pulse |
| ch_mode | output | 9 | Per-channel 3-bit counting mode, channel n in bits 3n+2:3n |
| ch_bcd | output | 3 | Per-channel decimal-count flag |
| ch_count | input | 48 | Per-channel live count from the counters |
| ch_out | input | 3 | Per-channel output level from the counters |

## Verification
Every result takes exactly one register stage. Read data, load pulses with their values, and mode or flag changes all appear in the cycle after the clock edge that samples the strobe. The driver raises a strobe for a single cycle and queues the byte that read should produce. The monitor notes each sampled read strobe at the rising edge and compares the next queued byte with the read data at the following falling edge. Load and mode outputs are compared at that same falling edge, directly after the write that produces them.

// File: rtl/timer_regif_pkg.sv
package timer_regif_pkg;
  localparam int BYTE_W = 8;
  localparam int CNT_W  = 16;
  localparam int MODE_W = 3;
  localparam int ACC_W  = 2;

  typedef enum logic [ACC_W-1:0] {
    ACC_LATCH = 2'd0,
    ACC_LO    = 2'd1,
    ACC_HI    = 2'd2,
    ACC_PAIR  = 2'd3
  } acc_e;
endpackage

// File: rtl/regif_decode.sv
module regif_decode
  import timer_regif_pkg::*;
#(
  parameter int N_CH = 3
) (
  input  logic [1:0]        addr,
  input  logic              wr,
  input  logic              rd,
  input  logic [BYTE_W-1:0] wdata,
  output logic [N_CH-1:0]   cw_set,
  output logic [N_CH-1:0]   cnt_lat,
  output logic [N_CH-1:0]   sts_lat,
  output logic [N_CH-1:0]   dat_wr,
  output logic [N_CH-1:0]   dat_rd
);
  logic       ctl_wr;
  logic       is_rb;
  logic [1:0] sel;
  logic [1:0] acc;

  always_comb begin
    ctl_wr = wr && (addr == 2'd3);
    sel    = wdata[7:6];
    acc    = wdata[5:4];
    is_rb  = (sel == 2'd3);
    for (int i = 0; i < N_CH; i++) begin
      cw_set[i]  = ctl_wr && !is_rb && (sel == 2'(i)) && (acc != ACC_LATCH);
      cnt_lat[i] = ctl_wr && ((!is_rb && (sel == 2'(i)) && (acc == ACC_LATCH)) ||
                              (is_rb && wdata[i+1] && !wdata[5]));
      sts_lat[i] = ctl_wr && is_rb && wdata[i+1] && !wdata[4];
      dat_wr[i]  = wr && (addr == 2'(i));
      dat_rd[i]  = rd && (addr == 2'(i));
    end
  end
endmodule

// File: rtl/regif_chan.sv
module regif_chan
  import timer_regif_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              cw_set,
  input  logic [BYTE_W-1:0] wdata,
  input  logic              cnt_lat,
  input  logic              sts_lat,
  input  logic              dat_wr,
  input  logic              dat_rd,
  input  logic [CNT_W-1:0]  cnt_in,
  input  logic              out_in,
  output logic [CNT_W-1:0]  load_val,
  output logic              load_stb,
  output logic [MODE_W-1:0] mode_o,
  output logic              bcd_o,
  output logic [BYTE_W-1:0] rd_byte
);
  logic [ACC_W-1:0]  acc_q;
  logic [MODE_W-1:0] mode_q;
  logic              bcd_q;
  logic              wr_hi_q, rd_hi_q;
  logic [BYTE_W-1:0] hold_q;
  logic [ACC_W-1:0]  lat_q;
  logic [CNT_W-1:0]  lat_cnt_q;
  logic              st_vld_q;
  logic [BYTE_W-1:0] st_q;

  assign mode_o = mode_q;
  assign bcd_o  = bcd_q;

  // read byte selection: status, then snapshot, then live count
  always_comb begin
    if (st_vld_q)
      rd_byte = st_q;
    else if (lat_q != ACC_LATCH)
      rd_byte = (lat_q == ACC_HI) ? lat_cnt_q[15:8] : lat_cnt_q[7:0];
    else if (acc_q == ACC_HI || (acc_q == ACC_PAIR && rd_hi_q))
      rd_byte = cnt_in[15:8];
    else
      rd_byte = cnt_in[7:0];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      acc_q     <= ACC_PAIR;
      mode_q    <= 3'd3;
      bcd_q     <= 1'b0;
      wr_hi_q   <= 1'b0;
      rd_hi_q   <= 1'b0;
      hold_q    <= '0;
      lat_q     <= ACC_LATCH;
      lat_cnt_q <= '0;
      st_vld_q  <= 1'b0;
      st_q      <= '0;
      load_val  <= '0;
      load_stb  <= 1'b0;
    end else begin
      load_stb <= 1'b0;
      // read side sequencing
      if (dat_rd) begin
        if (st_vld_q)
          st_vld_q <= 1'b0;
        else if (lat_q != ACC_LATCH)
          lat_q <= (lat_q == ACC_PAIR) ? ACC_HI : ACC_LATCH;
        else if (acc_q == ACC_PAIR)
          rd_hi_q <= !rd_hi_q;
      end
      // one-shot freezes
      if (cnt_lat && lat_q == ACC_LATCH) begin
        lat_cnt_q <= cnt_in;
        lat_q     <= acc_q;
      end
      if (sts_lat && !st_vld_q) begin
        st_q     <= {out_in, 1'b0, acc_q, mode_q, bcd_q};
        st_vld_q <= 1'b1;
      end
      // write side sequencing
      if (cw_set) begin
        acc_q   <= wdata[5:4];
        mode_q  <= wdata[3:1];
        bcd_q   <= wdata[0];
        wr_hi_q <= 1'b0;
        rd_hi_q <= 1'b0;
      end else if (dat_wr) begin
        case (acc_q)
          ACC_LO: begin
            load_val <= {8'h00, wdata};
            load_stb <= 1'b1;
          end
          ACC_HI: begin
            load_val <= {wdata, 8'h00};
            load_stb <= 1'b1;
          end
          default: begin
            if (!wr_hi_q) begin
              hold_q  <= wdata;
              wr_hi_q <= 1'b1;
            end else begin
              load_val <= {wdata, hold_q};
              load_stb <= 1'b1;
              wr_hi_q  <= 1'b0;
            end
          end
        endcase
      end
    end
  end

  assert_cw_apply_R1: assert property (@(posedge clk) disable iff (rst)
    cw_set |=> (mode_q == $past(wdata[3:1]) && acc_q == $past(wdata[5:4])));

  assert_status_hold_R5: assert property (@(posedge clk) disable iff (rst)
    (st_vld_q && !dat_rd) |=> (st_vld_q && $stable(st_q)));

  assert_count_hold_R5: assert property (@(posedge clk) disable iff (rst)
    (lat_q != ACC_LATCH && !dat_rd) |=> $stable(lat_cnt_q));

  assert_status_first_R6: assert property (@(posedge clk) disable iff (rst)
    (st_vld_q && dat_rd) |=> (lat_q == $past(lat_q)));

  assert_pair_latch_R10: assert property (@(posedge clk) disable iff (rst)
    (dat_rd && !st_vld_q && lat_q == ACC_PAIR) |=> (lat_q == ACC_HI));

  assert_ptr_reset_R11: assert property (@(posedge clk) disable iff (rst)
    cw_set |=> (!wr_hi_q && !rd_hi_q));

  assert_load_cause_R7: assert property (@(posedge clk) disable iff (rst)
    load_stb |-> $past(dat_wr));
endmodule

// File: rtl/timer_bus_regif.sv
module timer_bus_regif
  import timer_regif_pkg::*;
#(
  parameter int N_CH = 3
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic [1:0]              bus_addr,
  input  logic                    bus_wr,
  input  logic                    bus_rd,
  input  logic [BYTE_W-1:0]       bus_wdata,
  output logic [BYTE_W-1:0]       bus_rdata,
  output logic [N_CH*CNT_W-1:0]   ch_load_val,
  output logic [N_CH-1:0]         ch_load_stb,
  output logic [N_CH*MODE_W-1:0]  ch_mode,
  output logic [N_CH-1:0]         ch_bcd,
  input  logic [N_CH*CNT_W-1:0]   ch_count,
  input  logic [N_CH-1:0]         ch_out
);
  logic [N_CH-1:0]   cw_set, cnt_lat, sts_lat, dat_wr, dat_rd;
  logic [BYTE_W-1:0] rd_byte [N_CH];
  logic [BYTE_W-1:0] rd_mux;

  regif_decode #(.N_CH(N_CH)) u_dec (
    .addr    (bus_addr),
    .wr      (bus_wr),
    .rd      (bus_rd),
    .wdata   (bus_wdata),
    .cw_set  (cw_set),
    .cnt_lat (cnt_lat),
    .sts_lat (sts_lat),
    .dat_wr  (dat_wr),
    .dat_rd  (dat_rd)
  );

  for (genvar g = 0; g < N_CH; g++) begin : g_ch
    regif_chan u_chan (
      .clk      (clk),
      .rst      (rst),
      .cw_set   (cw_set[g]),
      .wdata    (bus_wdata),
      .cnt_lat  (cnt_lat[g]),
      .sts_lat  (sts_lat[g]),
      .dat_wr   (dat_wr[g]),
      .dat_rd   (dat_rd[g]),
      .cnt_in   (ch_count[g*CNT_W +: CNT_W]),
      .out_in   (ch_out[g]),
      .load_val (ch_load_val[g*CNT_W +: CNT_W]),
      .load_stb (ch_load_stb[g]),
      .mode_o   (ch_mode[g*MODE_W +: MODE_W]),
      .bcd_o    (ch_bcd[g]),
      .rd_byte  (rd_byte[g])
    );
  end

  always_comb begin
    rd_mux = '0;
    for (int i = 0; i < N_CH; i++)
      if (bus_addr == 2'(i)) rd_mux = rd_byte[i];
  end

  always_ff @(posedge clk) begin
    if (rst)
      bus_rdata <= '0;
    else if (bus_rd)
      bus_rdata <= rd_mux;
  end

  assert_ctl_read_zero_R12: assert property (@(posedge clk) disable iff (rst)
    (bus_rd && bus_addr == 2'd3) |=> (bus_rdata == 8'h00));

  assert_ctl_no_load_R12: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && bus_addr == 2'd3) |=> (ch_load_stb == '0));

  assert_single_load_R7: assert property (@(posedge clk) disable iff (rst)
    $onehot0(ch_load_stb));
endmodule

// File: tb/timer_bus_regif_tb.sv
`timescale 1ns/1ps
module timer_bus_regif_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [1:0]  bus_addr = 2'd0;
  logic        bus_wr = 1'b0;
  logic        bus_rd = 1'b0;
  logic [7:0]  bus_wdata = 8'h00;
  logic [7:0]  bus_rdata;
  logic [47:0] ch_load_val;
  logic [2:0]  ch_load_stb;
  logic [8:0]  ch_mode;
  logic [2:0]  ch_bcd;
  logic [47:0] ch_count = 48'h0;
  logic [2:0]  ch_out = 3'b000;

  int checks = 0;
  int errors = 0;
  bit reported = 0;
  logic rd_seen = 1'b0;
  logic [7:0] exp_q [$];
  string      tag_q [$];

  always #2.5 clk = ~clk;

  timer_bus_regif u_dut (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .ch_load_val(ch_load_val),
    .ch_load_stb(ch_load_stb), .ch_mode(ch_mode), .ch_bcd(ch_bcd),
    .ch_count(ch_count), .ch_out(ch_out)
  );

  task automatic chk(string tag, logic [15:0] act, logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic report();
    if (!reported) begin
      reported = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
    end
  endtask

  // monitor: compare queued read bytes one cycle after the strobe
  always @(posedge clk) rd_seen <= bus_rd && !rst;

  always @(negedge clk) begin
    if (rd_seen) begin
      if (exp_q.size() == 0) begin
        checks++; errors++;
        $display("FAIL scoreboard: unexpected read actual=%h expected=none", bus_rdata);
      end else begin
        chk(tag_q.pop_front(), {8'h00, bus_rdata}, {8'h00, exp_q.pop_front()});
      end
    end
  end

  task automatic wr(logic [1:0] a, logic [7:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(logic [1:0] a, logic [7:0] e, string tag);
    @(negedge clk);
    bus_addr = a; bus_rd = 1'b1;
    exp_q.push_back(e); tag_q.push_back(tag);
    @(negedge clk);
    bus_rd = 1'b0;
  endtask

  task automatic set_cnt(int ch, logic [15:0] v);
    ch_count[ch*16 +: 16] = v;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    report();
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R13 reset state
    chk("R13 mode ch0", {13'd0, ch_mode[2:0]}, 16'd3);
    chk("R13 mode ch2", {13'd0, ch_mode[8:6]}, 16'd3);
    chk("R13 bcd", {13'd0, ch_bcd}, 16'd0);
    chk("R13 load_stb", {13'd0, ch_load_stb}, 16'd0);
    chk("R13 rdata", {8'd0, bus_rdata}, 16'd0);
    // R12 control address reads zero
    set_cnt(0, 16'hBEEF);
    rd(2'd3, 8'h00, "R12 read addr3");
    // R7 pair write on ch0 (reset access = pair)
    wr(2'd0, 8'h34);
    chk("R7 first byte held", {13'd0, ch_load_stb}, 16'd0);
    wr(2'd0, 8'h12);
    chk("R7 pair strobe", {13'd0, ch_load_stb}, 16'd1);
    chk("R7 pair value", ch_load_val[15:0], 16'h1234);
    // R1 control word ch1: low-only, mode 2, bcd 1
    wr(2'd3, 8'h55);
    chk("R12 no load from control", {13'd0, ch_load_stb}, 16'd0);
    chk("R1 mode ch1", {13'd0, ch_mode[5:3]}, 16'd2);
    chk("R1 bcd ch1", {15'd0, ch_bcd[1]}, 16'd1);
    wr(2'd1, 8'hAB);
    chk("R8 low-only value", ch_load_val[31:16], 16'h00AB);
    chk("R8 low-only strobe", {13'd0, ch_load_stb}, 16'd2);
    // ch2 high-only, mode 0
    wr(2'd3, 8'hA0);
    wr(2'd2, 8'hCD);
    chk("R8 high-only value", ch_load_val[47:32], 16'hCD00);
    // R9 live reads
    set_cnt(1, 16'h1357);
    set_cnt(2, 16'h2468);
    rd(2'd1, 8'h57, "R9 low-only live");
    rd(2'd1, 8'h57, "R9 low-only live again");
    rd(2'd2, 8'h24, "R9 high-only live");
    rd(2'd0, 8'hEF, "R9 pair live low");
    rd(2'd0, 8'hBE, "R9 pair live high");
    rd(2'd0, 8'hEF, "R9 pair live low again");
    // R11 pointer reset on control word
    wr(2'd3, 8'h38);
    chk("R1 mode ch0", {13'd0, ch_mode[2:0]}, 16'd4);
    rd(2'd0, 8'hEF, "R11 read pointer reset");
    wr(2'd0, 8'h11);
    wr(2'd3, 8'h38);
    wr(2'd0, 8'h22);
    wr(2'd0, 8'h33);
    chk("R11 write pointer reset", ch_load_val[15:0], 16'h3322);
    // R2 count latch, R5 no overwrite, R10 pair snapshot
    wr(2'd3, 8'h00);
    chk("R2 mode kept", {13'd0, ch_mode[2:0]}, 16'd4);
    chk("R2 bcd kept", {15'd0, ch_bcd[0]}, 16'd0);
    set_cnt(0, 16'h5A6B);
    rd(2'd0, 8'hEF, "R10 snapshot low");
    wr(2'd3, 8'h00);
    rd(2'd0, 8'hBE, "R5 snapshot high not overwritten");
    rd(2'd0, 8'h6B, "R10 released to live");
    // R3/R4/R6 read-back of ch1 count and status
    ch_out[1] = 1'b1;
    wr(2'd3, 8'hC4);
    set_cnt(1, 16'h9999);
    rd(2'd1, 8'h95, "R6 status first R4");
    rd(2'd1, 8'h57, "R6 snapshot second");
    rd(2'd1, 8'h99, "R6 live last");
    // R3 status-only read-back of ch1 and ch2
    ch_out[1] = 1'b0;
    ch_out[2] = 1'b0;
    wr(2'd3, 8'hEC);
    ch_out[2] = 1'b1;
    wr(2'd3, 8'hE8);
    rd(2'd2, 8'h20, "R5 status not overwritten R4");
    rd(2'd2, 8'h24, "R3 ch2 live after status");
    rd(2'd1, 8'h15, "R3 ch1 status R4");
    rd(2'd1, 8'h99, "R3 no count frozen");
    rd(2'd0, 8'h5A, "R3 unselected ch0 live");
    // R3 count-only read-back of ch0
    wr(2'd3, 8'hD2);
    set_cnt(0, 16'h0F0F);
    rd(2'd0, 8'h6B, "R3 frozen low");
    rd(2'd0, 8'h5A, "R10 frozen high");
    rd(2'd0, 8'h0F, "R10 live after release");
    // R10 single-byte snapshot release
    set_cnt(1, 16'h1234);
    wr(2'd3, 8'h40);
    set_cnt(1, 16'h4321);
    rd(2'd1, 8'h34, "R10 low-only snapshot");
    rd(2'd1, 8'h21, "R10 low-only released");
    repeat (2) @(negedge clk);
    chk("scoreboard drained", 16'(exp_q.size()), 16'd0);
    report();
    $finish;
  end
endmodule